// File: doc/BRIEF.md
# Serial Register-Access Slave with Burst Pointer and Time-Register Hold

This block is a serial-peripheral slave that gives a host read and write access to a 64-byte register space. The host pulls an active-low select line low, then clocks a header byte: the leading bit chooses the direction and the remaining seven bits give the starting address. Data bytes then stream in on the data input or out on the data output. After each complete byte the internal pointer advances, so one frame can cover many consecutive registers. The pointer wraps at the top of the space.

The lowest eight registers mirror a set of timekeeping counters that live outside the block. The counters raise a one-cycle update request together with a 64-bit snapshot of the time. While a frame has its pointer inside the time range, the block asserts a hold output and does not copy new snapshots into those registers. The host therefore sees a consistent set of values. A request that arrives during the hold is remembered and applied as soon as the hold ends. All serial inputs are brought into the system clock domain through synchronizers, and edges are detected there.

Top module: `sreg_slave`

## Requirements
- R1: Header and data bits move most significant bit first. The data input is sampled on the rising serial clock edge, and the data output changes on the falling serial clock edge.
- R2: The first header bit selects the direction: 1 makes every following byte a write, and 0 makes every following byte a read.
- R3: Header bits two to eight form a 7-bit start address. Only its low six bits select a register, so address 45h reaches register 05h.
- R4: While select stays low, the pointer advances by one after each complete data byte, in both directions.
- R5: The pointer advances from 3Fh to 00h.
- R6: In the data phase of a read or write frame, the hold output is high exactly while the pointer is in 00h to 07h. While it is high, registers 00h to 07h are not overwritten by update requests.
- R7: The hold output goes low when select goes high, or when the pointer moves to 08h or above.
- R8: An update request copies byte i of the time snapshot (bits 8i+7 down to 8i) into register i for i from 0 to 7. A request made during the hold is kept and applied once the hold ends.
- R9: A write byte that is cut short by select going high does not change any register.
- R10: The output enable is low whenever no frame is open, and high during a frame.
- R11: After reset, every register reads 00h and the hold and output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for sdo; the pad floats when low |
| tick_req | input | 1 | One-cycle update request from the timekeeping counters |
| time_in | input | 64 | Time snapshot, byte i for register i |
| clk_hold | output | 1 | High while the time registers are frozen for the host |

## Verification
On every cycle the assertions check these rules: the hold stays inside the time range and drops with the output enable; no snapshot is copied while the hold is high; a request made during the hold is always latched; a register write happens only at a byte boundary; and the pointer wraps from the top address to zero. Some behaviour can only be shown by the bench's scenarios, because it depends on the data the host sees across whole frames. This covers bit order, the direction bit, address aliasing, burst contents across the wrap, the frozen values returned during a hold, the delayed snapshot appearing afterwards, and the discarding of a partial byte.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Pointer step with wrap at the top of the space.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p + 1) % depth;
  endfunction

  // True when the pointer addresses one of the mirrored time registers.
  function automatic bit in_time_range(input int unsigned p, input int unsigned nclk);
    return p < nclk;
  endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int CLK_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              byte_done,
  output logic              hdr_done,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_t            phase;
  logic              sck_q, sel_q;
  logic              is_wr;
  logic [CNT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] rx_sh, rx_nx, tx_sh;
  logic              sdo_q;
  logic              sck_rise, sck_fall, framing;

  assign framing  = !sel_n_s && !sel_q && (phase != PH_IDLE);
  assign sck_rise = framing && sck_s && !sck_q;
  assign sck_fall = framing && !sck_s && sck_q;
  assign rx_nx    = {rx_sh[DATA_W-2:0], sdi_s};

  assign byte_done = sck_rise && (bit_idx == LAST_BIT) && (phase == PH_DATA);
  assign hdr_done  = sck_rise && (bit_idx == LAST_BIT) && (phase == PH_HDR);
  assign wr_en     = byte_done && is_wr;
  assign wr_data   = rx_nx;

  assign sdo_oe = (phase != PH_IDLE);
  assign sdo    = sdo_q && sdo_oe;
  assign hold   = (phase == PH_DATA) &&
                  in_time_range(int'(ptr), CLK_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      sel_q   <= 1'b1;
      phase   <= PH_IDLE;
      is_wr   <= 1'b0;
      bit_idx <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      sdo_q   <= 1'b0;
      ptr     <= '0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel_n_s;
      if (sel_n_s) begin
        phase   <= PH_IDLE;
        bit_idx <= '0;
        sdo_q   <= 1'b0;
      end else if (sel_q) begin
        phase   <= PH_HDR;
        bit_idx <= '0;
        sdo_q   <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= rx_nx;
          bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
          if (hdr_done) begin
            is_wr <= rx_nx[DATA_W-1];
            ptr   <= rx_nx[ADDR_W-1:0];
            phase <= PH_DATA;
          end else if (byte_done) begin
            ptr <= ADDR_W'(ptr_step(int'(ptr), DEPTH));
          end
        end
        if (sck_fall && (phase == PH_DATA) && !is_wr) begin
          if (bit_idx == '0) begin
            sdo_q <= rd_byte[DATA_W-1];
            tx_sh <= {rd_byte[DATA_W-2:0], 1'b0};
          end else begin
            sdo_q <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/sreg_file.sv
module sreg_file #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int CLK_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       hold,
  input  logic                       tick_req,
  input  logic [CLK_REGS*DATA_W-1:0] time_in,
  output logic                       upd_fire,
  output logic                       pend
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_data  = mem[addr];
  assign upd_fire = !hold && (pend || tick_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (upd_fire) pend <= 1'b0;
    else if (tick_req) pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (upd_fire)
        for (int i = 0; i < CLK_REGS; i++) mem[i] <= time_in[i*DATA_W +: DATA_W];
      if (wr_en) mem[addr] <= wr_data;
    end
  end

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int CLK_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_n,
  input  logic                       sck,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_oe,
  input  logic                       tick_req,
  input  logic [CLK_REGS*DATA_W-1:0] time_in,
  output logic                       clk_hold
);

  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] ptr;
  logic              wr_en, byte_done, hdr_done, upd_fire, pend;
  logic [DATA_W-1:0] wr_data, rd_byte;

  sreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sck, sdi}), .q(pins_s)
  );

  sreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_REGS(CLK_REGS)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sel_n_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rd_byte(rd_byte), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .byte_done(byte_done), .hdr_done(hdr_done),
    .sdo(sdo), .sdo_oe(sdo_oe), .hold(clk_hold)
  );

  sreg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_REGS(CLK_REGS)) u_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wr_data(wr_data),
    .rd_data(rd_byte), .hold(clk_hold), .tick_req(tick_req), .time_in(time_in),
    .upd_fire(upd_fire), .pend(pend)
  );

endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk #(
  parameter int ADDR_W   = 6,
  parameter int CLK_REGS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo_oe,
  input logic              clk_hold,
  input logic [ADDR_W-1:0] ptr,
  input logic              byte_done,
  input logic              wr_en,
  input logic              upd_fire,
  input logic              pend,
  input logic              tick_req
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  AST_HOLD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |-> (ptr < ADDR_W'(CLK_REGS)));                           // R6
  AST_HOLD_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !clk_hold);                                            // R7
  AST_NO_UPD_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> !clk_hold);                                           // R6
  AST_TICK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_req && clk_hold) |=> pend);                                  // R8
  AST_WRITE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> byte_done);                                              // R9
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ptr == TOP) |=> (ptr == '0));                        // R5

endmodule

bind sreg_slave sreg_slave_chk #(.ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_oe(sdo_oe), .clk_hold(clk_hold), .ptr(ptr),
  .byte_done(byte_done), .wr_en(wr_en), .upd_fire(upd_fire), .pend(pend),
  .tick_req(tick_req)
);

// File: tb/sreg_slave_bench.sv
module sreg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel_n = 1'b1, sck = 1'b0, sdi = 1'b0, tick_req = 1'b0;
  logic [63:0] time_in = '0;
  logic        sdo, sdo_oe, clk_hold;
  int          checks = 0, errors = 0, cycles = 0;
  logic [7:0]  rx;

  sreg_slave u_sreg_slave (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .tick_req(tick_req), .time_in(time_in), .clk_hold(clk_hold)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      got[i] = sdo;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic open_frame(input logic wr, input logic [6:0] a);
    logic [7:0] d;
    wait_clk(1);
    sel_n = 1'b0;
    wait_clk(HALF);
    xfer({wr, a}, d);
  endtask

  task automatic close_frame();
    wait_clk(HALF);
    sel_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic pulse_tick(input logic [63:0] t);
    wait_clk(1);
    time_in = t; tick_req = 1'b1;
    wait_clk(1);
    tick_req = 1'b0;
    wait_clk(4);
  endtask

  task automatic read_one(input logic [6:0] a, output logic [7:0] v);
    open_frame(1'b0, a);
    xfer(8'h00, v);
    close_frame();
  endtask

  function automatic logic [63:0] snap(input logic [7:0] base);
    logic [63:0] s;
    for (int i = 0; i < 8; i++) s[i*8 +: 8] = base + 8'(i);
    return s;
  endfunction

  task automatic t_reset();
    chk(clk_hold == 1'b0, "R11 hold after reset", 64'(clk_hold), 0);
    chk(sdo_oe == 1'b0, "R11 oe after reset", 64'(sdo_oe), 0);
    read_one(7'h2A, rx);
    chk(rx == 8'h00, "R11 register after reset", 64'(rx), 0);
  endtask

  task automatic t_burst();
    logic [7:0] v [3] = '{8'h81, 8'h3C, 8'hE7};
    open_frame(1'b1, 7'h10);
    chk(sdo_oe == 1'b1, "R10 oe in frame", 64'(sdo_oe), 1);
    for (int i = 0; i < 3; i++) xfer(v[i], rx);
    close_frame();
    chk(sdo_oe == 1'b0, "R10 oe after frame", 64'(sdo_oe), 0);
    open_frame(1'b0, 7'h10);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, rx);
      chk(rx == v[i], "R1 R2 R4 burst readback", 64'(rx), 64'(v[i]));
    end
    close_frame();
    read_one(7'h11, rx);
    chk(rx == 8'h3C, "R4 second register", 64'(rx), 64'h3C);
  endtask

  task automatic t_alias();
    open_frame(1'b1, 7'h6A);
    xfer(8'h5D, rx);
    close_frame();
    read_one(7'h2A, rx);
    chk(rx == 8'h5D, "R3 upper address bit ignored", 64'(rx), 64'h5D);
  endtask

  task automatic t_wrap();
    open_frame(1'b1, 7'h3F);
    xfer(8'hA5, rx);
    xfer(8'hC3, rx);
    close_frame();
    read_one(7'h00, rx);
    chk(rx == 8'hC3, "R5 write wrapped to 00h", 64'(rx), 64'hC3);
    open_frame(1'b0, 7'h3F);
    xfer(8'h00, rx);
    chk(rx == 8'hA5, "R5 read at 3Fh", 64'(rx), 64'hA5);
    xfer(8'h00, rx);
    chk(rx == 8'hC3, "R5 read wrapped to 00h", 64'(rx), 64'hC3);
    close_frame();
  endtask

  task automatic t_partial();
    open_frame(1'b1, 7'h20);
    xfer(8'h96, rx);
    for (int i = 7; i >= 3; i--) begin
      sdi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    close_frame();
    read_one(7'h20, rx);
    chk(rx == 8'h96, "R9 full byte kept", 64'(rx), 64'h96);
    read_one(7'h21, rx);
    chk(rx == 8'h00, "R9 partial byte discarded", 64'(rx), 0);
  endtask

  task automatic t_write_hold();
    open_frame(1'b1, 7'h03);
    chk(clk_hold == 1'b1, "R6 hold in write frame", 64'(clk_hold), 1);
    xfer(8'h77, rx);
    close_frame();
    chk(clk_hold == 1'b0, "R7 hold released on deselect", 64'(clk_hold), 0);
    read_one(7'h03, rx);
    chk(rx == 8'h77, "R2 write into time register", 64'(rx), 64'h77);
  endtask

  task automatic t_tick_hold();
    pulse_tick(snap(8'h10));
    read_one(7'h04, rx);
    chk(rx == 8'h14, "R8 idle update applied", 64'(rx), 64'h14);
    open_frame(1'b0, 7'h06);
    chk(clk_hold == 1'b1, "R6 hold in read frame", 64'(clk_hold), 1);
    pulse_tick(snap(8'hA0));
    chk(clk_hold == 1'b1, "R6 hold kept across request", 64'(clk_hold), 1);
    xfer(8'h00, rx);
    chk(rx == 8'h16, "R6 frozen value at 06h", 64'(rx), 64'h16);
    xfer(8'h00, rx);
    chk(rx == 8'h17, "R6 frozen value at 07h", 64'(rx), 64'h17);
    chk(clk_hold == 1'b0, "R7 hold released at 08h", 64'(clk_hold), 0);
    close_frame();
    read_one(7'h00, rx);
    chk(rx == 8'hA0, "R8 deferred update reg 0", 64'(rx), 64'hA0);
    read_one(7'h07, rx);
    chk(rx == 8'hA7, "R8 deferred update reg 7", 64'(rx), 64'hA7);
    read_one(7'h10, rx);
    chk(rx == 8'h81, "R8 update leaves 10h alone", 64'(rx), 64'h81);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_burst();
    t_alias();
    t_wrap();
    t_partial();
    t_write_hold();
    t_tick_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule